// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block is a synthesizable I2C target that looks to a host like a small serial EEPROM. A fast system clock samples the bus clock and data lines and a glitch filter cleans both. START and STOP conditions come from the filtered lines. The block then decodes the device-select byte and serves byte writes, page writes, current-address reads, random reads and sequential reads. The array sits in internal registers and its capacity, set by `KBIT`, is 1, 2, 4, 8 or 16 Kbit. The array always consists of 16-byte pages.

A write gives a word address and then data bytes. The data go into a 16-byte page buffer. At STOP the buffered bytes are copied into the array in one timed internal write cycle of `WR_CYCLES` clocks. While that cycle runs the target refuses its select byte, so a host can poll until the array is ready. A write-protect input that is high at STOP blocks that copy. At the larger capacities the low address pins take no part in device selection, and the select-byte bits in those positions become the top memory-address bits.

Top module: `i2c_eeprom_tgt`

## Requirements
- R1: A select byte is acknowledged only when its bits [7:4] are 4'b1010. Bit 0 is the direction: 1 means read and 0 means write.
- R2: The number of high address bits is HB = max(0, log2(KBIT*1024/8) - 8). Select bit [i+1] is compared with `a_pins[i]` only for i >= HB. For i < HB the pin is ignored and the select bit becomes memory-address bit 8+i. With KBIT=4, select bit 1 is address bit 8.
- R3: A byte write of one data byte to an address, followed by a random read of that address, returns the byte that was written.
- R4: During page loading the low four address bits wrap inside the current 16-byte page. When more than 16 bytes are sent, the later bytes overwrite the earliest ones.
- R5: A STOP that ends a write with at least one data byte starts an internal write cycle. The buffer is committed when that cycle ends. For the whole cycle the select byte is not acknowledged, and it is acknowledged again once the cycle is over.
- R6: If `wp` is high at STOP, the data bytes are still acknowledged, but no internal write cycle starts and the array is left unchanged. The next select byte is acknowledged at once.
- R7: Reads return one byte after another from the internal address counter. The counter increments after each byte and rolls over from the last location to 0. A current-address read continues from where the previous access left the counter.
- R8: A pulse shorter than `FILT_LEN` clocks on SCL or SDA is ignored. Such a pulse on SDA while SCL is high does not act as a START or a STOP.
- R9: Transfers work at an SCL rate of 100 kHz and at 400 kHz with a 50 MHz system clock.
- R10: After reset and after any START, `sda_oe` is low.
- R11: `sda_oe` is asserted only while the filtered SCL is low, and it is released after a STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, many times faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| a_pins | input | 3 | Device address pins |
| wp | input | 1 | Write protect, active high, to be tied low when not driven |

## Verification
Two functions can coincide in one transaction: a host poll arriving while the internal write cycle is still running, and the decode of a select byte. The bench provokes this by sending a select byte right after the STOP of a write. It expects no acknowledge in that case, and it expects an acknowledge after the cycle has elapsed. A second overlap puts a filtered glitch in the middle of a data bit. An SDA pulse during SCL high and a short SCL low pulse land in the same bit, and the byte must still be stored unchanged at a high-bank address. Expected contents come from a model array in the bench that is updated by the page-wrap and write-protect rules.

// File: rtl/eep_pkg.sv
package eep_pkg;

  typedef enum logic [2:0] {ST_IDLE, ST_DEV, ST_ADDR, ST_WDATA, ST_RDATA} st_t;
  typedef enum logic [1:0] {PH_RX, PH_ACK, PH_TX, PH_MACK} ph_t;

  // address width of an array of kbit kilobits
  function automatic int addr_bits(input int kbit);
    return $clog2(kbit * 128);
  endfunction

  // select-byte bits reused as high memory address bits
  function automatic int hi_bits(input int kbit);
    int aw;
    aw = addr_bits(kbit);
    return (aw > 8) ? aw - 8 : 0;
  endfunction

  // compare only the pins that still take part in selection
  function automatic logic pin_ok(input logic [2:0] sel, input logic [2:0] pins,
                                  input int hb);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < 3; i++)
      if (i >= hb && sel[i] != pins[i]) ok = 1'b0;
    return ok;
  endfunction

endpackage

// File: rtl/i2c_deglitch.sv
module i2c_deglitch #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync <= 2'b11;
      dout <= 1'b1;
      cnt  <= '0;
    end else begin
      sync <= {sync[0], din};
      if (sync[1] == dout)
        cnt <= '0;
      else if (cnt == CW'(FILT_LEN - 1)) begin
        dout <= sync[1];
        cnt  <= '0;
      end else
        cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/i2c_cond.sv
module i2c_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic ev_start,
  output logic ev_stop,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign ev_start = scl_q & scl_f & sda_q & ~sda_f;
  assign ev_stop  = scl_q & scl_f & ~sda_q & sda_f;
  assign scl_rise = ~scl_q & scl_f;
  assign scl_fall = scl_q & ~scl_f;
endmodule

// File: rtl/eep_wcycle.sv
module eep_wcycle #(
  parameter int WR_CYCLES = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic busy,
  output logic commit
);
  localparam int CW = $clog2(WR_CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (go) begin
        busy <= 1'b1;
        cnt  <= CW'(WR_CYCLES - 1);
      end
    end else if (cnt == '0)
      busy <= 1'b0;
    else
      cnt <= cnt - 1'b1;
  end

  assign commit = busy && (cnt == '0);
endmodule

// File: rtl/i2c_eeprom_tgt.sv
module i2c_eeprom_tgt #(
  parameter int KBIT      = 2,
  parameter int FILT_LEN  = 4,
  parameter int WR_CYCLES = 5000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] a_pins,
  input  logic       wp
);
  import eep_pkg::*;

  localparam int AW    = addr_bits(KBIT);
  localparam int DEPTH = 1 << AW;
  localparam int HB    = hi_bits(KBIT);

  // named internal events
  logic scl_f, sda_f, ev_start, ev_stop, scl_rise, scl_fall;
  logic wc_go, wc_busy, wc_commit, sel_ok;

  logic [1:0] raw, filt;
  assign raw   = {sda_i, scl_i};
  assign scl_f = filt[0];
  assign sda_f = filt[1];

  for (genvar g = 0; g < 2; g++) begin : g_filt
    i2c_deglitch #(.FILT_LEN(FILT_LEN)) u_flt (
      .clk(clk), .rst_n(rst_n), .din(raw[g]), .dout(filt[g]));
  end

  i2c_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
    .ev_start(ev_start), .ev_stop(ev_stop),
    .scl_rise(scl_rise), .scl_fall(scl_fall));

  st_t          st;
  ph_t          ph;
  logic [3:0]   bitc;
  logic [7:0]   sh;
  logic [2:0]   hi;
  logic [AW-1:0] addr;
  logic         mack, wr_pend;
  logic [7:0]   pbuf [16];
  logic [15:0]  mask;
  logic [7:0]   mem  [DEPTH];
  logic [7:0]   rd_byte;

  assign rd_byte = mem[addr];
  assign sel_ok  = (sh[7:4] == 4'b1010) && pin_ok(sh[3:1], a_pins, HB) && !wc_busy;
  assign wc_go   = ev_stop && wr_pend && !wp;

  eep_wcycle #(.WR_CYCLES(WR_CYCLES)) u_wc (
    .clk(clk), .rst_n(rst_n), .go(wc_go), .busy(wc_busy), .commit(wc_commit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      ph      <= PH_RX;
      bitc    <= '0;
      sh      <= '0;
      hi      <= '0;
      addr    <= '0;
      mack    <= 1'b0;
      wr_pend <= 1'b0;
      mask    <= '0;
      sda_oe  <= 1'b0;
      for (int i = 0; i < 16; i++) pbuf[i] <= '0;
    end else if (ev_start) begin
      st      <= ST_DEV;
      ph      <= PH_RX;
      bitc    <= '0;
      sda_oe  <= 1'b0;
      wr_pend <= 1'b0;
    end else if (ev_stop) begin
      st      <= ST_IDLE;
      sda_oe  <= 1'b0;
      wr_pend <= 1'b0;
    end else if (st != ST_IDLE) begin
      unique case (ph)
        PH_RX: begin
          if (scl_rise && bitc < 4'd8) begin
            sh   <= {sh[6:0], sda_f};
            bitc <= bitc + 1'b1;
          end else if (scl_fall && bitc == 4'd8) begin
            case (st)
              ST_DEV: if (sel_ok) begin
                sda_oe <= 1'b1;
                ph     <= PH_ACK;
                hi     <= sh[3:1];
                st     <= sh[0] ? ST_RDATA : ST_ADDR;
                if (!sh[0]) mask <= '0;
              end else
                st <= ST_IDLE;
              ST_ADDR: begin
                addr   <= AW'({hi, sh});
                sda_oe <= 1'b1;
                ph     <= PH_ACK;
                st     <= ST_WDATA;
              end
              ST_WDATA: begin
                pbuf[addr[3:0]] <= sh;
                mask[addr[3:0]] <= 1'b1;
                addr[3:0]       <= addr[3:0] + 1'b1;
                wr_pend         <= 1'b1;
                sda_oe          <= 1'b1;
                ph              <= PH_ACK;
              end
              default: st <= ST_IDLE;
            endcase
          end
        end
        PH_ACK: if (scl_fall) begin
          bitc <= '0;
          if (st == ST_RDATA) begin
            sh     <= rd_byte;
            sda_oe <= ~rd_byte[7];
            addr   <= addr + 1'b1;
            ph     <= PH_TX;
          end else begin
            sda_oe <= 1'b0;
            ph     <= PH_RX;
          end
        end
        PH_TX: if (scl_fall) begin
          if (bitc == 4'd7) begin
            sda_oe <= 1'b0;
            ph     <= PH_MACK;
          end else begin
            bitc   <= bitc + 1'b1;
            sh     <= {sh[6:0], 1'b0};
            sda_oe <= ~sh[6];
          end
        end
        PH_MACK: begin
          if (scl_rise) mack <= ~sda_f;
          else if (scl_fall) begin
            if (mack) begin
              bitc   <= '0;
              sh     <= rd_byte;
              sda_oe <= ~rd_byte[7];
              addr   <= addr + 1'b1;
              ph     <= PH_TX;
            end else
              st <= ST_IDLE;
          end
        end
        default: ph <= PH_RX;
      endcase
    end
  end

  // array: every buffered byte lands in one clock at the end of the cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < DEPTH; j++) mem[j] <= 8'hFF;
    end else if (wc_commit) begin
      for (int i = 0; i < 16; i++)
        if (mask[i]) mem[{addr[AW-1:4], 4'(i)}] <= pbuf[i];
    end
  end
endmodule

// File: rtl/eep_tgt_chk.sv
module eep_tgt_chk (
  input logic clk,
  input logic rst_n,
  input logic wp,
  input logic sda_oe,
  input logic scl_f,
  input logic ev_start,
  input logic ev_stop,
  input logic wc_busy
);
  // R5
  busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wc_busy |-> !sda_oe);
  // R6
  wp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wc_busy) |-> $past(ev_stop && !wp));
  // R11
  oe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_f);
  // R10
  start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> !sda_oe);
  // R11
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> !sda_oe);
endmodule

bind i2c_eeprom_tgt eep_tgt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wp(wp), .sda_oe(sda_oe), .scl_f(scl_f),
  .ev_start(ev_start), .ev_stop(ev_stop), .wc_busy(wc_busy));

// File: tb/tb_i2c_eeprom_tgt.sv
module tb_i2c_eeprom_tgt;
  localparam int WRC = 3000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_h = 1'b1, sda_h = 1'b1, wp = 1'b0;
  logic [2:0] a_pins = 3'b101;
  logic sda_oe;
  wire  sda_line = sda_h & ~sda_oe;

  int n_chk = 0, n_fail = 0, H = 62;
  logic [7:0] exp_mem [512];

  always #10 clk = ~clk;

  i2c_eeprom_tgt #(.KBIT(4), .FILT_LEN(4), .WR_CYCLES(WRC)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_h), .sda_i(sda_line),
    .sda_oe(sda_oe), .a_pins(a_pins), .wp(wp));

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic hc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] dev(input logic hib, input logic rw);
    return {4'b1010, 2'b10, hib, rw};
  endfunction

  task automatic bstart();
    sda_h = 1'b1; hc(H); scl_h = 1'b1; hc(H); sda_h = 1'b0; hc(H); scl_h = 1'b0; hc(H/2);
  endtask

  task automatic bstop();
    sda_h = 1'b0; hc(H); scl_h = 1'b1; hc(H); sda_h = 1'b1; hc(H);
  endtask

  task automatic wb(input logic [7:0] b, input bit glitch, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_h = b[i]; hc(H); scl_h = 1'b1;
      if (glitch && i == 4) begin
        hc(H/2); sda_h = ~sda_h; hc(2); sda_h = ~sda_h; hc(4);
        scl_h = 1'b0; hc(2); scl_h = 1'b1; hc(H/2 - 8);
      end else
        hc(H);
      scl_h = 1'b0;
    end
    sda_h = 1'b1; hc(H); scl_h = 1'b1; hc(H/2);
    ack = ~sda_line;
    hc(H/2); scl_h = 1'b0;
  endtask

  task automatic rb(input bit ack_in, output logic [7:0] b);
    sda_h = 1'b1;
    for (int i = 0; i < 8; i++) begin
      hc(H); scl_h = 1'b1; hc(H/2); b = {b[6:0], sda_line}; hc(H/2); scl_h = 1'b0;
    end
    sda_h = ack_in ? 1'b0 : 1'b1; hc(H); scl_h = 1'b1; hc(H); scl_h = 1'b0;
    sda_h = 1'b1;
  endtask

  // page write of n bytes d0, d0+3, ... ; model follows the page wrap rule
  task automatic wr(input logic [8:0] a, input int n, input logic [7:0] d0,
                    input bit wpv, input bit glitch, input string req);
    bit ack;
    logic [7:0] d;
    logic [3:0] lo;
    wp = wpv;
    bstart();
    wb(dev(a[8], 1'b0), 1'b0, ack); chk(ack, req, ack, 1);
    wb(a[7:0], 1'b0, ack);          chk(ack, req, ack, 1);
    lo = a[3:0];
    for (int i = 0; i < n; i++) begin
      d = d0 + 8'(i * 3);
      wb(d, glitch, ack); chk(ack, req, ack, 1);
      if (!wpv) exp_mem[{a[8:4], lo}] = d;
      lo = lo + 1'b1;
    end
    bstop();
    wp = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, input int n, input string req);
    bit ack;
    logic [7:0] b;
    bstart();
    wb(dev(a[8], 1'b0), 1'b0, ack);
    wb(a[7:0], 1'b0, ack);
    bstart();
    wb(dev(1'b0, 1'b1), 1'b0, ack); chk(ack, req, ack, 1);
    for (int i = 0; i < n; i++) begin
      rb(i < n - 1, b);
      chk(b == exp_mem[9'(a + 9'(i))], req, b, exp_mem[9'(a + 9'(i))]);
    end
    bstop();
  endtask

  task automatic sel_probe(input logic [7:0] s, output bit ack);
    bstart(); wb(s, 1'b0, ack); bstop();
  endtask

  initial begin
    repeat (198000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] b;
    for (int i = 0; i < 512; i++) exp_mem[i] = 8'hFF;
    hc(10);
    chk(sda_oe == 1'b0, "R10 reset", sda_oe, 0);
    rst_n = 1'b1;
    hc(20);

    // R1: wrong type code
    sel_probe(8'hB4, ack);
    chk(!ack, "R1 type code", ack, 0);

    // R2: sweep select bits [3:1]; with pins 101 and HB=1 only bits [3:2]==10 matter
    for (int s = 0; s < 8; s++) begin
      sel_probe({4'b1010, 3'(s), 1'b0}, ack);
      chk(ack == (s[2:1] == 2'b10), "R2 pin sweep", ack, s[2:1] == 2'b10);
    end

    // R3 byte write, R5 poll during the cycle
    wr(9'h034, 1, 8'h5A, 1'b0, 1'b0, "R3 write");
    sel_probe(dev(1'b0, 1'b0), ack);
    chk(!ack, "R5 busy poll", ack, 0);
    hc(WRC);
    sel_probe(dev(1'b0, 1'b0), ack);
    chk(ack, "R5 ready poll", ack, 1);
    rd(9'h034, 1, "R3 readback");

    // R4: 18 bytes from mid page wrap and overwrite the first two
    wr(9'h057, 18, 8'h10, 1'b0, 1'b0, "R4 load");
    hc(WRC + 50);
    rd(9'h050, 16, "R4 page");

    // R6: protected write is acked, no busy, array unchanged
    wr(9'h034, 1, 8'hC3, 1'b1, 1'b0, "R6 ack");
    sel_probe(dev(1'b0, 1'b0), ack);
    chk(ack, "R6 no cycle", ack, 1);
    rd(9'h034, 1, "R6 unchanged");

    // R8 glitches in a data bit, R2 high bank via select bit 1
    wr(9'h134, 1, 8'hA7, 1'b0, 1'b1, "R8 glitch write");
    hc(WRC + 50);
    rd(9'h134, 1, "R8 R2 high bank");
    rd(9'h034, 1, "R2 low bank");

    // R7: rollover from the last location, then current-address read
    wr(9'h1FE, 3, 8'h61, 1'b0, 1'b0, "R7 setup");
    hc(WRC + 50);
    rd(9'h1FE, 3, "R7 rollover");
    bstart();
    wb(dev(1'b0, 1'b1), 1'b0, ack);
    rb(1'b0, b);
    bstop();
    chk(b == exp_mem[1], "R7 current address", b, exp_mem[1]);
    chk(exp_mem[9'h1F0] == 8'h67, "R4 wrap model", exp_mem[9'h1F0], 8'h67);
    rd(9'h1F0, 1, "R4 wrap to page start");

    // R9: write at 100 kHz, read back at 400 kHz
    H = 250;
    wr(9'h0A0, 1, 8'h3C, 1'b0, 1'b0, "R9 slow write");
    H = 62;
    hc(WRC + 50);
    rd(9'h0A0, 1, "R9 readback");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule